// File: doc/BRIEF.md
# Event-Triggered Register Replay Engine

This block plays back a prepared list of register writes onto a peripheral register bus whenever a chosen hardware event fires, so that time-critical reprogramming (for example at the start of every video frame) happens without waiting on an interrupt handler. Software writes the list into memory as pairs of 32-bit words, register address first and value second. It then gives the engine the byte address of the first word and the byte address of the last byte of the list, and picks which event starts a replay.

On each accepted trigger the engine captures its configuration, reads the words one at a time through a valid/ready memory read port, and issues one write per pair on a strobe/acknowledge register port, strictly in list order. When the last write is acknowledged it raises a done interrupt and stays armed for the next trigger. Sticky status bits report triggers lost to a running replay and lists with unusable bounds. A soft reset abandons any replay in progress.

Top module: `regseq_replay`

## Requirements
- R1: Each entry occupies 8 bytes: the word at entry offset 0 holds the target register address (low RAW bits used) and the word at offset 4 holds the value; the engine issues one write per entry in list order.
- R2: The end address is inclusive (last byte of the list), so a replay issues exactly (end - start + 1) / 8 writes.
- R3: Trigger select codes are 0 = stop (no trigger starts a replay), 1 = frame event, 2 = line event, 3 = manual start; only the selected source starts a replay.
- R4: After a replay finishes the engine stays armed and the next selected trigger replays the list again from the start address.
- R5: A trigger that arrives while a replay is running (including its final cycle) does not restart or extend it and sets the sticky overrun bit.
- R6: If end < start, or (end - start + 1) is not a multiple of 8, a trigger causes no memory read and no write, and sets the sticky error bit.
- R7: The memory request holds its address until mem_ready; each register write strobe lasts one cycle and the next write waits for reg_ack (accepted in the strobe cycle or later).
- R8: With the increment flag set, entry k targets the first entry's address plus k; address words of later entries are ignored.
- R9: With the write-direction flag clear, the list is walked without any write strobe and the done interrupt is still raised.
- R10: The done interrupt rises after the last entry completes and holds until irq clear; when completion and clear fall in the same cycle, the interrupt is set.
- R11: Soft reset returns the engine to idle at once, drops the memory request and strobe, clears interrupt and status bits, and no further writes of the abandoned list follow.
- R12: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start_addr | input | AW | Byte address of the first list word |
| cfg_end_addr | input | AW | Byte address of the last list byte |
| cfg_trig_sel | input | 2 | Trigger source select |
| cfg_write_dir | input | 1 | 1 = issue writes, 0 = walk only |
| cfg_addr_inc | input | 1 | 1 = targets increment from the first address |
| ctl_soft_reset | input | 1 | Pulse: abandon replay, clear status |
| ctl_irq_clear | input | 1 | Clears the done interrupt |
| ev_frame | input | 1 | Frame-start event pulse |
| ev_line | input | 1 | Line-count event pulse |
| sw_start | input | 1 | Manual start pulse |
| mem_req | output | 1 | Memory read request valid |
| mem_addr | output | AW | Memory read byte address |
| mem_ready | input | 1 | Memory accepts request; mem_rdata valid |
| mem_rdata | input | 32 | Memory read word |
| reg_wr | output | 1 | Register write strobe |
| reg_addr | output | RAW | Register write address |
| reg_wdata | output | 32 | Register write value |
| reg_ack | input | 1 | Register write acknowledge |
| irq_done | output | 1 | Done interrupt |
| sts_busy | output | 1 | Replay in progress |
| sts_overrun | output | 1 | Sticky: trigger lost while busy |
| sts_error | output | 1 | Sticky: bad list bounds |

## Verification
Completion of a replay and an interrupt clear can land in the same cycle; the bench holds the clear input high across a whole replay so that it overlaps the completing cycle, then requires the interrupt to be seen high for one cycle and low the cycle after. A trigger can likewise coincide with a running replay; a second manual start issued mid-list must leave the write count equal to one list and set the overrun bit.

// File: rtl/regseq_pkg.sv
package regseq_pkg;
  localparam int DW          = 32;
  localparam int WORD_BYTES  = 4;
  localparam int ENTRY_BYTES = 8;

  localparam logic [1:0] TRIG_STOP   = 2'd0;
  localparam logic [1:0] TRIG_FRAME  = 2'd1;
  localparam logic [1:0] TRIG_LINE   = 2'd2;
  localparam logic [1:0] TRIG_MANUAL = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_A,
    ST_FETCH_D,
    ST_STROBE,
    ST_WAIT_ACK,
    ST_ADVANCE
  } eng_state_e;
endpackage

// File: rtl/regseq_trig.sv
module regseq_trig
  import regseq_pkg::*;
(
  input  logic       clk,
  input  logic       srst,
  input  logic [1:0] sel,
  input  logic       ev_frame,
  input  logic       ev_line,
  input  logic       sw_start,
  output logic       go
);
  logic hit;

  always_comb begin
    unique case (sel)
      TRIG_FRAME:  hit = ev_frame;
      TRIG_LINE:   hit = ev_line;
      TRIG_MANUAL: hit = sw_start;
      default:     hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (srst) go <= 1'b0;
    else      go <= hit;
  end

  AST_STOP_NO_GO: assert property (@(posedge clk) disable iff (srst)
    (sel == TRIG_STOP) |=> !go); // R3
endmodule

// File: rtl/regseq_engine.sv
module regseq_engine
  import regseq_pkg::*;
#(
  parameter int AW  = 16,
  parameter int RAW = 16
) (
  input  logic           clk,
  input  logic           srst,
  input  logic           go,
  input  logic [AW-1:0]  cfg_start,
  input  logic [AW-1:0]  cfg_end,
  input  logic           cfg_write,
  input  logic           cfg_inc,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  input  logic           mem_ready,
  input  logic [DW-1:0]  mem_rdata,
  output logic           reg_wr,
  output logic [RAW-1:0] reg_addr,
  output logic [DW-1:0]  reg_wdata,
  input  logic           reg_ack,
  output logic           busy,
  output logic           done_evt,
  output logic           err_evt,
  output logic           ovr_evt
);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);
  localparam logic [AW-1:0] ONE  = AW'(1);

  eng_state_e     state_q;
  logic [AW-1:0]  ptr_q, last_q;
  logic [RAW-1:0] base_q, idx_q;
  logic           wr_en_q, inc_q;

  logic [AW-1:0]  span;
  logic           bad_bounds, accept, idle;
  logic [RAW-1:0] tgt_addr;

  assign span       = cfg_end - cfg_start;
  assign bad_bounds = (cfg_end < cfg_start) || (span[2:0] != 3'b111);
  assign accept     = mem_req && mem_ready;
  assign idle       = (state_q == ST_IDLE);
  assign tgt_addr   = (inc_q && idx_q != '0) ? base_q + idx_q : mem_rdata[RAW-1:0];

  assign done_evt = (state_q == ST_ADVANCE) && (ptr_q == last_q + ONE);
  assign err_evt  = go && idle && bad_bounds;
  assign ovr_evt  = go && !idle;

  always_ff @(posedge clk) begin
    if (srst) begin
      state_q   <= ST_IDLE;
      ptr_q     <= '0;
      last_q    <= '0;
      base_q    <= '0;
      idx_q     <= '0;
      wr_en_q   <= 1'b0;
      inc_q     <= 1'b0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      reg_wr    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      busy      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (go && !bad_bounds) begin
            ptr_q    <= cfg_start;
            last_q   <= cfg_end;
            wr_en_q  <= cfg_write;
            inc_q    <= cfg_inc;
            idx_q    <= '0;
            mem_req  <= 1'b1;
            mem_addr <= cfg_start;
            busy     <= 1'b1;
            state_q  <= ST_FETCH_A;
          end
        end
        ST_FETCH_A: begin
          if (accept) begin
            reg_addr <= tgt_addr;
            if (idx_q == '0) base_q <= mem_rdata[RAW-1:0];
            ptr_q    <= ptr_q + STEP;
            mem_addr <= ptr_q + STEP;
            state_q  <= ST_FETCH_D;
          end
        end
        ST_FETCH_D: begin
          if (accept) begin
            reg_wdata <= mem_rdata;
            ptr_q     <= ptr_q + STEP;
            mem_req   <= 1'b0;
            if (wr_en_q) begin
              reg_wr  <= 1'b1;
              state_q <= ST_STROBE;
            end else begin
              state_q <= ST_ADVANCE;
            end
          end
        end
        ST_STROBE: begin
          reg_wr  <= 1'b0;
          state_q <= reg_ack ? ST_ADVANCE : ST_WAIT_ACK;
        end
        ST_WAIT_ACK: begin
          if (reg_ack) state_q <= ST_ADVANCE;
        end
        ST_ADVANCE: begin
          idx_q <= idx_q + 1'b1;
          if (ptr_q == last_q + ONE) begin
            busy    <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            mem_req  <= 1'b1;
            mem_addr <= ptr_q;
            state_q  <= ST_FETCH_A;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (srst)
    reg_wr |=> !reg_wr); // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (srst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr))); // R7
  AST_BAD_NO_START: assert property (@(posedge clk) disable iff (srst)
    err_evt |=> (!mem_req && !busy)); // R6
  AST_NO_STROBE_READ: assert property (@(posedge clk) disable iff (srst)
    (busy && !wr_en_q) |-> !reg_wr); // R9
endmodule

// File: rtl/regseq_status.sv
module regseq_status (
  input  logic clk,
  input  logic srst,
  input  logic done_evt,
  input  logic err_evt,
  input  logic ovr_evt,
  input  logic irq_clear,
  output logic irq,
  output logic overrun,
  output logic error
);
  always_ff @(posedge clk) begin
    if (srst) begin
      irq     <= 1'b0;
      overrun <= 1'b0;
      error   <= 1'b0;
    end else begin
      if (done_evt)       irq <= 1'b1;
      else if (irq_clear) irq <= 1'b0;
      overrun <= overrun | ovr_evt;
      error   <= error | err_evt;
    end
  end

  AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (srst)
    done_evt |=> irq); // R10
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (srst)
    ovr_evt |=> overrun); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (srst)
    err_evt |=> error); // R6
endmodule

// File: rtl/regseq_replay.sv
module regseq_replay
  import regseq_pkg::*;
#(
  parameter int AW  = 16,
  parameter int RAW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  cfg_start_addr,
  input  logic [AW-1:0]  cfg_end_addr,
  input  logic [1:0]     cfg_trig_sel,
  input  logic           cfg_write_dir,
  input  logic           cfg_addr_inc,
  input  logic           ctl_soft_reset,
  input  logic           ctl_irq_clear,
  input  logic           ev_frame,
  input  logic           ev_line,
  input  logic           sw_start,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  input  logic           mem_ready,
  input  logic [31:0]    mem_rdata,
  output logic           reg_wr,
  output logic [RAW-1:0] reg_addr,
  output logic [31:0]    reg_wdata,
  input  logic           reg_ack,
  output logic           irq_done,
  output logic           sts_busy,
  output logic           sts_overrun,
  output logic           sts_error
);
  logic srst, go, done_evt, err_evt, ovr_evt;

  assign srst = rst || ctl_soft_reset;

  regseq_trig u_trig (
    .clk      (clk),
    .srst     (srst),
    .sel      (cfg_trig_sel),
    .ev_frame (ev_frame),
    .ev_line  (ev_line),
    .sw_start (sw_start),
    .go       (go)
  );

  regseq_engine #(.AW(AW), .RAW(RAW)) u_engine (
    .clk       (clk),
    .srst      (srst),
    .go        (go),
    .cfg_start (cfg_start_addr),
    .cfg_end   (cfg_end_addr),
    .cfg_write (cfg_write_dir),
    .cfg_inc   (cfg_addr_inc),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_ack   (reg_ack),
    .busy      (sts_busy),
    .done_evt  (done_evt),
    .err_evt   (err_evt),
    .ovr_evt   (ovr_evt)
  );

  regseq_status u_status (
    .clk       (clk),
    .srst      (srst),
    .done_evt  (done_evt),
    .err_evt   (err_evt),
    .ovr_evt   (ovr_evt),
    .irq_clear (ctl_irq_clear),
    .irq       (irq_done),
    .overrun   (sts_overrun),
    .error     (sts_error)
  );

  AST_SOFT_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    ctl_soft_reset |=> (!sts_busy && !mem_req && !reg_wr && !irq_done)); // R11
endmodule

// File: tb/test_regseq_replay.sv
`timescale 1ns/1ps
module test_regseq_replay;
  localparam int AW  = 16;
  localparam int RAW = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [AW-1:0]  cfg_start_addr = '0, cfg_end_addr = '0;
  logic [1:0]     cfg_trig_sel = 2'd0;
  logic           cfg_write_dir = 1'b1, cfg_addr_inc = 1'b0;
  logic           ctl_soft_reset = 1'b0, ctl_irq_clear = 1'b0;
  logic           ev_frame = 1'b0, ev_line = 1'b0, sw_start = 1'b0;
  logic           mem_req, mem_ready = 1'b0;
  logic [AW-1:0]  mem_addr;
  logic [31:0]    mem_rdata = '0;
  logic           reg_wr, reg_ack = 1'b0;
  logic [RAW-1:0] reg_addr;
  logic [31:0]    reg_wdata;
  logic           irq_done, sts_busy, sts_overrun, sts_error;

  regseq_replay #(.AW(AW), .RAW(RAW)) i_regseq_replay (.*);

  always #5 clk = ~clk;

  logic [31:0]    mem [64];
  logic [RAW-1:0] obs_addr [256];
  logic [31:0]    obs_data [256];
  int             obs_n = 0;
  int             n_chk = 0, n_bad = 0;
  int             ack_dly = 0;
  bit             ack_pend = 1'b0;
  bit             fixed_ack = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      mem_ready = mem_req && ($urandom % 3 != 0);
      mem_rdata = mem[mem_addr[7:2]];
    end
  end

  // register slave
  initial begin
    forever begin
      @(negedge clk);
      reg_ack = 1'b0;
      if (reg_wr) begin
        if (obs_n < 256) begin
          obs_addr[obs_n] = reg_addr;
          obs_data[obs_n] = reg_wdata;
        end
        obs_n++;
        ack_pend = 1'b1;
        ack_dly  = fixed_ack ? 0 : int'($urandom % 3);
      end
      if (ack_pend) begin
        if (ack_dly == 0) begin
          reg_ack  = 1'b1;
          ack_pend = 1'b0;
        end else ack_dly--;
      end
    end
  end

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  function automatic logic [RAW-1:0] exp_addr(input int start, input int k, input bit inc);
    int w = start / 4;
    if (inc) return mem[w][RAW-1:0] + RAW'(k);
    return mem[w + 2 * k][RAW-1:0];
  endfunction

  function automatic logic [31:0] exp_data(input int start, input int k);
    return mem[start / 4 + 2 * k + 1];
  endfunction

  task automatic fill(input int start, input int n);
    for (int i = 0; i < 2 * n; i++) mem[start / 4 + i] = $urandom;
  endtask

  task automatic setup(input int start, input int n, input bit inc, input bit wdir, input logic [1:0] sel);
    @(negedge clk);
    cfg_start_addr = AW'(start);
    cfg_end_addr   = AW'(start + 8 * n - 1);
    cfg_addr_inc   = inc;
    cfg_write_dir  = wdir;
    cfg_trig_sel   = sel;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      1: ev_frame = 1'b1;
      2: ev_line = 1'b1;
      3: sw_start = 1'b1;
      4: ctl_soft_reset = 1'b1;
      default: ctl_irq_clear = 1'b1;
    endcase
    @(negedge clk);
    ev_frame = 1'b0; ev_line = 1'b0; sw_start = 1'b0;
    ctl_soft_reset = 1'b0; ctl_irq_clear = 1'b0;
  endtask

  task automatic wait_irq(output bit seen);
    seen = 1'b0;
    for (int c = 0; c < 3000 && !seen; c++) begin
      @(negedge clk);
      if (irq_done) seen = 1'b1;
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int c = 0; c < n; c++) @(negedge clk);
  endtask

  task automatic compare(input int start, input int n, input bit inc, input string req);
    chk(obs_n == n, req, obs_n, n);
    for (int k = 0; k < n && k < obs_n; k++) begin
      chk(obs_addr[k] == exp_addr(start, k, inc), req, obs_addr[k], exp_addr(start, k, inc));
      chk(obs_data[k] == exp_data(start, k), req, obs_data[k], exp_data(start, k));
    end
  endtask

  task automatic run(input int start, input int n, input bit inc, input int src, input string req);
    bit seen;
    pulse(0);
    obs_n = 0;
    pulse(src);
    wait_irq(seen);
    chk(seen, {req, " done irq"}, seen, 1);
    idle_cycles(4);
    compare(start, n, inc, req);
  endtask

  initial begin
    bit seen;
    int start, n, src;
    bit inc;
    int saved;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) mem[i] = $urandom;
    idle_cycles(3);
    @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk({mem_req, reg_wr, irq_done, sts_busy, sts_overrun, sts_error} == 6'b0, "R12", 
        {mem_req, reg_wr, irq_done, sts_busy, sts_overrun, sts_error}, 0);

    // R1 R2 R7: manual trigger, three entries
    setup(16, 3, 1'b0, 1'b1, 2'd3);
    run(16, 3, 1'b0, 3, "R1");
    chk(irq_done == 1'b1, "R10 irq holds", irq_done, 1);
    pulse(0);
    chk(irq_done == 1'b0, "R10 irq clear", irq_done, 0);

    // R4: same list replayed on next trigger
    run(16, 3, 1'b0, 3, "R4");

    // R2 single-entry list
    fill(64, 1);
    setup(64, 1, 1'b0, 1'b1, 2'd3);
    run(64, 1, 1'b0, 3, "R2");

    // R3: frame select ignores line and manual
    fill(32, 2);
    setup(32, 2, 1'b0, 1'b1, 2'd1);
    pulse(0); obs_n = 0;
    pulse(2); pulse(3);
    idle_cycles(20);
    chk(obs_n == 0 && !sts_busy, "R3 wrong source", obs_n, 0);
    run(32, 2, 1'b0, 1, "R3 frame");
    setup(32, 2, 1'b0, 1'b1, 2'd2);
    pulse(0); obs_n = 0;
    pulse(1); pulse(3);
    idle_cycles(20);
    chk(obs_n == 0, "R3 wrong source line", obs_n, 0);
    run(32, 2, 1'b0, 2, "R3 line");
    setup(32, 2, 1'b0, 1'b1, 2'd0);
    pulse(0); obs_n = 0;
    pulse(1); pulse(2); pulse(3);
    idle_cycles(20);
    chk(obs_n == 0 && !irq_done, "R3 stop", obs_n, 0);

    // R8: increment mode
    fill(96, 5);
    setup(96, 5, 1'b1, 1'b1, 2'd3);
    run(96, 5, 1'b1, 3, "R8");

    // R9: walk without writes
    setup(96, 5, 1'b0, 1'b0, 2'd3);
    pulse(0); obs_n = 0;
    pulse(3);
    wait_irq(seen);
    chk(seen, "R9 done irq", seen, 1);
    chk(obs_n == 0, "R9 no strobes", obs_n, 0);

    // R10: clear held across completion, set wins
    fixed_ack = 1'b1;
    setup(16, 3, 1'b0, 1'b1, 2'd3);
    obs_n = 0;
    @(negedge clk); ctl_irq_clear = 1'b1;
    pulse(3);
    ctl_irq_clear = 1'b1;
    wait_irq(seen);
    chk(seen, "R10 set wins over clear", seen, 1);
    @(negedge clk);
    chk(irq_done == 1'b0, "R10 clear next cycle", irq_done, 0);
    ctl_irq_clear = 1'b0;
    fixed_ack = 1'b0;
    idle_cycles(4);
    compare(16, 3, 1'b0, "R10 list");

    // R5: trigger while busy
    fill(128, 6);
    setup(128, 6, 1'b0, 1'b1, 2'd3);
    pulse(0); obs_n = 0;
    chk(sts_overrun == 1'b0, "R5 overrun initial", sts_overrun, 0);
    pulse(3);
    idle_cycles(5);
    pulse(3);
    wait_irq(seen);
    idle_cycles(30);
    chk(sts_overrun == 1'b1, "R5 overrun set", sts_overrun, 1);
    compare(128, 6, 1'b0, "R5 single replay");

    // R6: bad bounds
    pulse(0); obs_n = 0;
    @(negedge clk);
    cfg_start_addr = AW'(80); cfg_end_addr = AW'(40);
    pulse(3);
    idle_cycles(20);
    chk(obs_n == 0 && !irq_done, "R6 end below start", obs_n, 0);
    chk(sts_error == 1'b1, "R6 error set", sts_error, 1);
    @(negedge clk);
    cfg_start_addr = AW'(80); cfg_end_addr = AW'(80 + 11);
    pulse(3);
    idle_cycles(20);
    chk(obs_n == 0 && !irq_done, "R6 odd length", obs_n, 0);

    // R11: soft reset mid-list
    fill(160, 8);
    setup(160, 8, 1'b0, 1'b1, 2'd3);
    obs_n = 0;
    pulse(3);
    for (int c = 0; c < 3000 && obs_n < 2; c++) @(negedge clk);
    @(negedge clk); ctl_soft_reset = 1'b1;
    @(negedge clk); ctl_soft_reset = 1'b0;
    chk(!sts_busy && !mem_req && !reg_wr, "R11 idle", {sts_busy, mem_req, reg_wr}, 0);
    chk(!sts_overrun && !sts_error && !irq_done, "R11 status clear",
        {sts_overrun, sts_error, irq_done}, 0);
    saved = obs_n;
    idle_cycles(40);
    chk(obs_n == saved, "R11 no further writes", obs_n, saved);
    run(160, 8, 1'b0, 3, "R11 restart");

    // random lists
    for (int it = 0; it < 20; it++) begin
      start = int'($urandom % 24) * 8;
      n     = 1 + int'($urandom % 8);
      inc   = $urandom % 2;
      src   = 1 + int'($urandom % 3);
      fill(start, n);
      setup(start, n, inc, 1'b1, 2'(src));
      run(start, n, inc, src, inc ? "R8 random" : "R1 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule